// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a processor's operand request and an external bus. It accepts one operand transfer at a time: a byte, a word, a three-byte remainder or a long word, with its start address, its direction and, for writes, its data. It then runs as many external bus cycles as the addressed port needs. Each cycle presents a two-bit size code for the bytes still outstanding, the current byte address and, on writes, the data lanes.

The addressed port answers each cycle with an active-low two-bit size acknowledge. That acknowledge states whether the port is 8 or 16 bits wide, and the block learns the width again on every cycle. From the answer it works out how many bytes moved and advances the address. The leftover is re-encoded as a smaller operand case. For example, a long word to an 8-bit port continues as a three-byte case, then a word case, then a byte case.

Read bytes are gathered most significant first into a right-justified 32-bit result. A one-cycle done pulse marks the end of the transfer. Requests whose start address does not suit their size are refused with a one-cycle reject pulse and start no bus cycle.

Top module: `dbs_seq`

## Requirements
- R1: While a cycle is active, `bus_size` encodes the bytes still outstanding: 2'b01 for one, 2'b10 for two, 2'b11 for three and 2'b00 for four. A three-byte case always sits at an odd address and a word case always sits at an even address.
- R2: A word (2'b10) or long-word (2'b00) request at an odd address, or a three-byte (2'b11) request at an even address, produces `req_reject` high for exactly one cycle, one clock after the request. No bus cycle starts for it.
- R3: `bus_ack_n` = 2'b10 ends a cycle as an 8-bit port and 2'b01 ends it as a 16-bit port. The values 2'b11 and 2'b00 are wait states, during which size, address and data stay unchanged. The width is taken afresh on each cycle.
- R4: A 16-bit port at an even address moves two bytes when two or more remain, and the address advances by 2. A long word therefore takes two cycles: the most significant word first, then a word case.
- R5: An 8-bit port moves one byte per cycle on `bus_din[15:8]`/`bus_dout[15:8]`, and the address advances by 1. A long word runs as size codes 00, 11, 10, 01 at addresses A, A+1, A+2, A+3.
- R6: On writes, when one byte remains or the address is odd, the next byte is driven on both lanes. Otherwise the next byte goes on [15:8] and the one after it on [7:0]. Write data is right-justified in `req_wdata`.
- R7: Read bytes arrive most significant first. The result on `xfer_rdata` is right-justified (a byte in [7:0], a word in [15:0], three bytes in [23:0]) and is valid in the cycle `xfer_done` is high.
- R8: `xfer_done` is high for exactly one cycle, one clock after the acknowledge that ends the last cycle. `bus_cyc` is low in that cycle.
- R9: A request is taken only while `req_ready` is high. Request inputs are ignored while a transfer runs. A request presented in the done cycle is taken at that clock edge, and its first bus cycle follows at once.
- R10: A 16-bit port at an odd address moves one byte, which is read from and written on [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code (R1 encoding) |
| req_addr | input | ADDR_W | Start byte address |
| req_wdata | input | 32 | Right-justified write operand |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| bus_cyc | output | 1 | External bus cycle in progress |
| bus_write | output | 1 | Direction of the current cycle |
| bus_size | output | 2 | Size code of outstanding bytes |
| bus_addr | output | ADDR_W | Current byte address |
| bus_dout | output | 16 | Write data lanes |
| bus_ack_n | input | 2 | Active-low port size acknowledge |
| bus_din | input | 16 | Read data lanes |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_rdata | output | 32 | Assembled read operand |

## Verification
The completion pulse and the taking of the next request can fall in the same cycle: the sequencer returns to idle exactly as `xfer_done` rises. The bench provokes this by holding `req_valid` high from the start of one transfer and changing the request fields to a second operand while the first is still on the bus. It judges the outcome in three steps. The first transfer's address must not be disturbed. The first result must be intact in the done cycle. The second operand's first bus cycle must appear on the very next clock with the fields that were present at that edge.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int OP_BYTES = 4;
    localparam int BYTE_W   = 8;
    localparam int OP_W     = OP_BYTES * BYTE_W;
    localparam int LANE_W   = 2 * BYTE_W;

    localparam logic [1:0] SZ_LONG   = 2'b00;
    localparam logic [1:0] SZ_BYTE   = 2'b01;
    localparam logic [1:0] SZ_WORD   = 2'b10;
    localparam logic [1:0] SZ_TRIPLE = 2'b11;

    localparam logic [1:0] ACK_NARROW = 2'b10;
    localparam logic [1:0] ACK_WIDE   = 2'b01;

    function automatic logic [2:0] size_to_count(input logic [1:0] s);
        return (s == SZ_LONG) ? 3'd4 : {1'b0, s};
    endfunction

    function automatic logic [1:0] count_to_size(input logic [2:0] n);
        return n[1:0];
    endfunction
endpackage

// File: rtl/dbs_step.sv
module dbs_step
    import dbs_pkg::*;
(
    input  logic [1:0] ack_n,
    input  logic [2:0] remain,
    input  logic       addr_odd,
    output logic       ack_ok,
    output logic       wide_port,
    output logic [2:0] moved
);
    always_comb begin
        wide_port = (ack_n == ACK_WIDE);
        ack_ok    = wide_port || (ack_n == ACK_NARROW);
        if (!wide_port || addr_odd || remain < 3'd2) moved = 3'd1;
        else                                         moved = 3'd2;
    end
endmodule

// File: rtl/dbs_lanes.sv
module dbs_lanes
    import dbs_pkg::*;
(
    input  logic [2:0]        remain,
    input  logic              addr_odd,
    input  logic              wide_port,
    input  logic [OP_W-1:0]   wbuf,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic [BYTE_W-1:0] first_byte,
    output logic [BYTE_W-1:0] second_byte
);
    logic [BYTE_W-1:0] head_b, next_b;

    always_comb begin
        head_b = wbuf[OP_W-1 -: BYTE_W];
        next_b = wbuf[OP_W-BYTE_W-1 -: BYTE_W];
        if (remain == 3'd1 || addr_odd) dout = {head_b, head_b};
        else                            dout = {head_b, next_b};
        first_byte  = (wide_port && addr_odd) ? din[BYTE_W-1:0] : din[LANE_W-1 -: BYTE_W];
        second_byte = din[BYTE_W-1:0];
    end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OP_W-1:0]   req_wdata,
    output logic              req_ready,
    output logic              req_reject,
    output logic              bus_cyc,
    output logic              bus_write,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LANE_W-1:0] bus_dout,
    input  logic [1:0]        bus_ack_n,
    input  logic [LANE_W-1:0] bus_din,
    output logic              xfer_done,
    output logic [OP_W-1:0]   xfer_rdata
);
    typedef struct packed {
        logic              busy;
        logic              write;
        logic              done;
        logic              reject;
        logic [2:0]        remain;
        logic [ADDR_W-1:0] addr;
        logic [OP_W-1:0]   wbuf;
        logic [OP_W-1:0]   rbuf;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic              ack_ok, wide_port;
    logic [2:0]        moved;
    logic [BYTE_W-1:0] first_byte, second_byte;
    logic              legal;

    dbs_step u_step (
        .ack_n     (bus_ack_n),
        .remain    (st_q.remain),
        .addr_odd  (st_q.addr[0]),
        .ack_ok    (ack_ok),
        .wide_port (wide_port),
        .moved     (moved)
    );

    dbs_lanes u_lanes (
        .remain      (st_q.remain),
        .addr_odd    (st_q.addr[0]),
        .wide_port   (wide_port),
        .wbuf        (st_q.wbuf),
        .din         (bus_din),
        .dout        (bus_dout),
        .first_byte  (first_byte),
        .second_byte (second_byte)
    );

    always_comb begin
        legal = (req_size == SZ_BYTE)
             || ((req_size == SZ_TRIPLE) && req_addr[0])
             || (((req_size == SZ_WORD) || (req_size == SZ_LONG)) && !req_addr[0]);
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.reject = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                if (legal) begin
                    st_d.busy   = 1'b1;
                    st_d.write  = req_write;
                    st_d.remain = size_to_count(req_size);
                    st_d.addr   = req_addr;
                    st_d.rbuf   = '0;
                    case (req_size)
                        SZ_LONG:   st_d.wbuf = req_wdata;
                        SZ_TRIPLE: st_d.wbuf = req_wdata << BYTE_W;
                        SZ_WORD:   st_d.wbuf = req_wdata << (2 * BYTE_W);
                        default:   st_d.wbuf = req_wdata << (3 * BYTE_W);
                    endcase
                end else begin
                    st_d.reject = 1'b1;
                end
            end
        end else if (ack_ok) begin
            if (moved == 3'd2) begin
                st_d.wbuf = st_q.wbuf << (2 * BYTE_W);
                st_d.rbuf = {st_q.rbuf[OP_W-2*BYTE_W-1:0], first_byte, second_byte};
            end else begin
                st_d.wbuf = st_q.wbuf << BYTE_W;
                st_d.rbuf = {st_q.rbuf[OP_W-BYTE_W-1:0], first_byte};
            end
            st_d.addr   = st_q.addr + ADDR_W'(moved);
            st_d.remain = st_q.remain - moved;
            if (st_q.remain == moved) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready  = !st_q.busy;
    assign req_reject = st_q.reject;
    assign bus_cyc    = st_q.busy;
    assign bus_write  = st_q.write;
    assign bus_size   = count_to_size(st_q.remain);
    assign bus_addr   = st_q.addr;
    assign xfer_done  = st_q.done;
    assign xfer_rdata = st_q.rbuf;

    // R1: outstanding-size cases sit on their required address parity
    p_triple_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_size == SZ_TRIPLE) |-> bus_addr[0]);
    p_word_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_size == SZ_WORD) |-> !bus_addr[0]);
    // R2: a refused request never opens a bus cycle
    p_reject_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> !bus_cyc);
    // R3: a wait state holds address and size
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !ack_ok) |=> ($stable(bus_addr) && $stable(bus_size) && bus_cyc));
    // R4: wide even cycle with two or more bytes left advances by two
    p_wide_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ack_n == ACK_WIDE && !bus_addr[0] && st_q.remain > 3'd2)
        |=> (bus_addr == $past(bus_addr) + ADDR_W'(2)));
    // R5: narrow cycle advances by one
    p_narrow_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ack_n == ACK_NARROW && st_q.remain > 3'd1)
        |=> (bus_addr == $past(bus_addr) + ADDR_W'(1)));
    // R8: completion is a single-cycle pulse outside any bus cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !bus_cyc);
endmodule

// File: tb/dbs_seq_tb_top.sv
`timescale 1ns/1ps
module dbs_seq_tb_top;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_size = 2'b01;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, req_reject, bus_cyc, bus_write, xfer_done;
    logic [1:0]    bus_size;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_dout;
    logic [1:0]    bus_ack_n = 2'b11;
    logic [15:0]   bus_din = '0;
    logic [31:0]   xfer_rdata;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dbs_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_reject(req_reject), .bus_cyc(bus_cyc),
        .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_ack_n(bus_ack_n), .bus_din(bus_din),
        .xfer_done(xfer_done), .xfer_rdata(xfer_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // One bus cycle seen from the port side; called at a negedge
    task automatic cycle(input string tag, input logic wide, input logic [1:0] esz,
                         input logic [AW-1:0] ea, input logic ckd, input logic [15:0] ed,
                         input logic [15:0] din, input int waits);
        chk({tag, " bus_cyc"}, 32'(bus_cyc), 32'd1);
        chk({tag, " size R1"}, 32'(bus_size), 32'(esz));
        chk({tag, " addr"}, 32'(bus_addr), 32'(ea));
        if (ckd) chk({tag, " dout R6"}, 32'(bus_dout), 32'(ed));
        for (int i = 0; i < waits; i++) begin
            bus_ack_n = (i == 1) ? 2'b00 : 2'b11;
            bus_din = 16'hFFFF;
            @(negedge clk);
            chk({tag, " wait size R3"}, 32'(bus_size), 32'(esz));
            chk({tag, " wait addr R3"}, 32'(bus_addr), 32'(ea));
        end
        bus_ack_n = wide ? 2'b01 : 2'b10;
        bus_din = din;
        @(negedge clk);
        bus_ack_n = 2'b11;
        bus_din = 16'h0000;
    endtask

    task automatic finish_chk(input string tag, input logic rd, input logic [31:0] er);
        chk({tag, " done R8"}, 32'(xfer_done), 32'd1);
        chk({tag, " cyc low R8"}, 32'(bus_cyc), 32'd0);
        if (rd) chk({tag, " rdata R7"}, xfer_rdata, er);
        @(negedge clk);
        chk({tag, " done pulse R8"}, 32'(xfer_done), 32'd0);
    endtask

    task automatic t_reset();
        chk("reset ready", 32'(req_ready), 32'd1);
        chk("reset cyc", 32'(bus_cyc), 32'd0);
        chk("reset done R8", 32'(xfer_done), 32'd0);
        chk("reset reject R2", 32'(req_reject), 32'd0);
    endtask

    task automatic t_byte_odd_wide();      // R10
        issue(1'b0, 2'b01, 24'h000101, 32'h0);
        cycle("R10 byte rd", 1'b1, 2'b01, 24'h000101, 1'b0, 16'h0, 16'hAA55, 0);
        finish_chk("R10 byte rd", 1'b1, 32'h00000055);
        issue(1'b1, 2'b01, 24'h000103, 32'h0000009E);
        cycle("R10 byte wr", 1'b1, 2'b01, 24'h000103, 1'b1, 16'h9E9E, 16'h0, 0);
        finish_chk("R10 byte wr", 1'b0, 32'h0);
    endtask

    task automatic t_long_wide_write();    // R4
        issue(1'b1, 2'b00, 24'h000200, 32'h11223344);
        chk("R4 write dir", 32'(bus_write), 32'd1);
        cycle("R4 long c1", 1'b1, 2'b00, 24'h000200, 1'b1, 16'h1122, 16'h0, 0);
        cycle("R4 long c2", 1'b1, 2'b10, 24'h000202, 1'b1, 16'h3344, 16'h0, 0);
        finish_chk("R4 long", 1'b0, 32'h0);
    endtask

    task automatic t_long_narrow();        // R5
        issue(1'b0, 2'b00, 24'h000040, 32'h0);
        cycle("R5 rd c1", 1'b0, 2'b00, 24'h000040, 1'b0, 16'h0, 16'hDE11, 0);
        cycle("R5 rd c2", 1'b0, 2'b11, 24'h000041, 1'b0, 16'h0, 16'hAD22, 0);
        cycle("R5 rd c3", 1'b0, 2'b10, 24'h000042, 1'b0, 16'h0, 16'hBE33, 0);
        cycle("R5 rd c4", 1'b0, 2'b01, 24'h000043, 1'b0, 16'h0, 16'hEF44, 0);
        finish_chk("R5 rd", 1'b1, 32'hDEADBEEF);
        issue(1'b1, 2'b00, 24'h000040, 32'hA1B2C3D4);
        cycle("R6 wr c1", 1'b0, 2'b00, 24'h000040, 1'b1, 16'hA1B2, 16'h0, 0);
        cycle("R6 wr c2", 1'b0, 2'b11, 24'h000041, 1'b1, 16'hB2B2, 16'h0, 0);
        cycle("R6 wr c3", 1'b0, 2'b10, 24'h000042, 1'b1, 16'hC3D4, 16'h0, 0);
        cycle("R6 wr c4", 1'b0, 2'b01, 24'h000043, 1'b1, 16'hD4D4, 16'h0, 0);
        finish_chk("R6 wr", 1'b0, 32'h0);
    endtask

    task automatic t_word_waits();         // R3, R7
        issue(1'b0, 2'b10, 24'h000010, 32'h0);
        cycle("R3 word c1", 1'b0, 2'b10, 24'h000010, 1'b0, 16'h0, 16'h5A00, 3);
        cycle("R3 word c2", 1'b0, 2'b01, 24'h000011, 1'b0, 16'h0, 16'hA5FF, 2);
        finish_chk("R7 word", 1'b1, 32'h00005AA5);
    endtask

    task automatic t_mixed_width();        // R3 width per cycle
        issue(1'b0, 2'b00, 24'h000080, 32'h0);
        cycle("R3 mix c1", 1'b0, 2'b00, 24'h000080, 1'b0, 16'h0, 16'h12FF, 0);
        cycle("R3 mix c2", 1'b1, 2'b11, 24'h000081, 1'b0, 16'h0, 16'hFF34, 0);
        cycle("R3 mix c3", 1'b1, 2'b10, 24'h000082, 1'b0, 16'h0, 16'h5678, 0);
        finish_chk("R3 mix", 1'b1, 32'h12345678);
    endtask

    task automatic t_triple();             // R1
        issue(1'b1, 2'b11, 24'h000021, 32'h00AABBCC);
        cycle("R1 tri c1", 1'b1, 2'b11, 24'h000021, 1'b1, 16'hAAAA, 16'h0, 0);
        cycle("R1 tri c2", 1'b1, 2'b10, 24'h000022, 1'b1, 16'hBBCC, 16'h0, 0);
        finish_chk("R1 tri", 1'b0, 32'h0);
    endtask

    task automatic t_reject_one(input string tag, input logic [1:0] sz, input logic [AW-1:0] a);
        issue(1'b0, sz, a, 32'h0);
        chk({tag, " reject R2"}, 32'(req_reject), 32'd1);
        chk({tag, " no cyc R2"}, 32'(bus_cyc), 32'd0);
        @(negedge clk);
        chk({tag, " reject pulse R2"}, 32'(req_reject), 32'd0);
        chk({tag, " still idle R2"}, 32'(bus_cyc), 32'd0);
    endtask

    task automatic t_back_to_back();       // R9
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'b01; req_addr = 24'h000030;
        @(negedge clk);
        req_write = 1'b1; req_size = 2'b10; req_addr = 24'h000060; req_wdata = 32'h0000BEEF;
        chk("R9 busy not ready", 32'(req_ready), 32'd0);
        cycle("R9 first", 1'b0, 2'b01, 24'h000030, 1'b0, 16'h0, 16'h7700, 1);
        chk("R9 done", 32'(xfer_done), 32'd1);
        chk("R9 rdata R7", xfer_rdata, 32'h00000077);
        chk("R9 ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 second wr", 32'(bus_write), 32'd1);
        cycle("R9 second", 1'b1, 2'b10, 24'h000060, 1'b1, 16'hBEEF, 16'h0, 0);
        finish_chk("R9 second", 1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_odd_wide();
        t_long_wide_write();
        t_long_narrow();
        t_word_waits();
        t_mixed_width();
        t_triple();
        t_reject_one("word odd", 2'b10, 24'h000011);
        t_reject_one("long odd", 2'b00, 24'h000013);
        t_reject_one("triple even", 2'b11, 24'h000014);
        t_back_to_back();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule